// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square signed matrices, C = A x B, on a mesh of identical multiply-accumulate cells. Each cell owns one element of C and keeps it in its own accumulator for the whole computation. A cell takes one operand from above and one from the left. It adds their product to its total and passes both operands on, one cycle later, to the cell below and the cell to its right. The default mesh is 2x2 with 8-bit operands and 18-bit totals.

A single-cycle `start` pulse captures both input matrices, clears every total and every operand in flight, and begins a run of 3*DIM-2 compute cycles (4 for the default size). A feeder drives the left edge with the rows of A and the top edge with the columns of B. Row i and column j are delayed by i and j cycles, and zeros are sent before and after each stream. Each element of C therefore finishes on its own cycle. The cell in the top-left corner finishes first and the bottom-right cell finishes last. `done` pulses once after the last compute cycle, and the totals then stay on `c_mat` until the next start.

Matrix element (r,c), counted from 0, uses slice index r*DIM+c in `a_mat`, `b_mat` and `c_mat`.

Top module: `sa_matmul`

## Requirements
- R1: After reset, and in the cycle after any `start`, every total on `c_mat` reads 0. `done` is 0 after reset.
- R2: When a run completes, element (i,j) of `c_mat` equals the sum over k of A(i,k)*B(k,j), with all values treated as two's-complement signed. This includes the extreme operands -128 and 127.
- R3: Element (0,0) holds its final value after the 2nd compute edge following the start edge. After the 1st compute edge it holds only A(0,0)*B(0,0).
- R4: Elements (0,1) and (1,0) reach their final values after the 3rd compute edge. After the 2nd edge they hold only A(0,0)*B(0,1) and A(1,0)*B(0,0). After the 3rd edge, element (1,1) holds only A(1,0)*B(0,1), and before that edge it holds 0.
- R5: Element (1,1) reaches its final value after the 4th compute edge.
- R6: `busy` is 1 from the start edge until the last compute edge. `done` is 1 for exactly one cycle, immediately after the last compute edge, and is never 1 together with `busy`.
- R7: Once `done` has risen, `c_mat` keeps its value until the next `start`. Changes on `a_mat` and `b_mat` after a start edge do not affect the results of that run or the held totals.
- R8: A `start` during a run abandons that run. The totals clear, and the new matrices are computed with the full timing of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: capture matrices, clear totals, begin a run |
| a_mat | input | DIM*DIM*OP_W | Matrix A, element (r,c) at slice r*DIM+c, signed |
| b_mat | input | DIM*DIM*OP_W | Matrix B, element (r,c) at slice r*DIM+c, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final compute edge |
| c_mat | output | DIM*DIM*ACC_W | Totals, element (r,c) at slice r*DIM+c, signed |

## Verification
Call the edge that takes `start` edge 0. C(0,0) is due after edge 2, C(0,1) and C(1,0) after edge 3, and C(1,1) and `done` after edge 4. `done` falls again after edge 5. The bench drives inputs on falling edges and samples on the falling edge that follows each rising edge. It checks every partial sum at each of these points, so an element that is early or late by one cycle shows up as a wrong partial value. The hold, restart and input-change scenarios use the same edge counting.

// File: rtl/sa_pkg.sv
package sa_pkg;

   // Compute cycles for a DIM x DIM mesh: the last cell sees its final operand pair
   // after 2*(DIM-1) cycles of skew plus DIM operand pairs.
   function automatic int run_steps(input int dim);
      return 3 * dim - 2;
   endfunction

   // Smallest accumulator width that cannot overflow for a full dot product.
   function automatic int acc_width_min(input int op_w, input int dim);
      return 2 * op_w + $clog2(dim);
   endfunction

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } phase_t;

endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
   import sa_pkg::*;
#(
   parameter int DIM = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start,
   output logic [$clog2(run_steps(DIM)+1)-1:0]  step,
   output logic                                 en,
   output logic                                 clr,
   output logic                                 busy,
   output logic                                 done
);
   localparam int NSTEP  = run_steps(DIM);
   localparam int STEP_W = $clog2(NSTEP + 1);

   phase_t phase_q;
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= '0;
      end else if (start) begin
         phase_q <= PH_RUN;
         step_q  <= STEP_W'(1);
      end else begin
         case (phase_q)
            PH_RUN: begin
               if (step_q == STEP_W'(NSTEP)) begin
                  phase_q <= PH_DONE;
                  step_q  <= '0;
               end else begin
                  step_q  <= step_q + STEP_W'(1);
               end
            end
            PH_DONE: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign step = step_q;
   assign busy = (phase_q == PH_RUN);
   assign done = (phase_q == PH_DONE);
   assign en   = busy && !start;
   assign clr  = start;

   // R6: done lasts exactly one cycle unless a new run begins
   p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: the last compute step is followed by done
   p_last_step_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step_q == STEP_W'(NSTEP) && !start) |=> done);

   // R6: the step counter stays inside the run window while busy
   p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step_q >= STEP_W'(1) && step_q <= STEP_W'(NSTEP)));

   // R8: a start always begins a fresh run at step 1
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && step_q == STEP_W'(1)));

endmodule

// File: rtl/sa_feeder.sv
module sa_feeder
   import sa_pkg::*;
#(
   parameter int DIM  = 2,
   parameter int OP_W = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start,
   input  logic [DIM*DIM*OP_W-1:0]              a_mat,
   input  logic [DIM*DIM*OP_W-1:0]              b_mat,
   input  logic [$clog2(run_steps(DIM)+1)-1:0]  step,
   output logic signed [OP_W-1:0]               left_edge [DIM],
   output logic signed [OP_W-1:0]               top_edge  [DIM]
);
   localparam int NSTEP  = run_steps(DIM);
   localparam int STEP_W = $clog2(NSTEP + 1);
   localparam int NELEM  = DIM * DIM;

   logic signed [OP_W-1:0] a_q [NELEM];
   logic signed [OP_W-1:0] b_q [NELEM];

   // Matrices are captured on the start edge so later input changes are ignored.
   for (genvar e = 0; e < NELEM; e++) begin : g_cap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            a_q[e] <= '0;
            b_q[e] <= '0;
         end else if (start) begin
            a_q[e] <= a_mat[e*OP_W +: OP_W];
            b_q[e] <= b_mat[e*OP_W +: OP_W];
         end
      end
   end

   // Row r of A enters the left edge r cycles late, so at step s it carries
   // A(r, s-1-r); column c of B enters the top edge c cycles late. Outside
   // each stream's window the edge carries zero.
   for (genvar r = 0; r < DIM; r++) begin : g_edge
      always_comb begin
         left_edge[r] = '0;
         top_edge[r]  = '0;
         for (int k = 0; k < DIM; k++) begin
            if (step == STEP_W'(r + k + 1)) begin
               left_edge[r] = a_q[r*DIM + k];
               top_edge[r]  = b_q[k*DIM + r];
            end
         end
      end
   end

   // R4: with no run step active both edges are zero-padded
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |-> (left_edge[0] == '0 && top_edge[0] == '0));

   // R7: the capture registers follow the ports only on a start edge
   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (a_q[0] == $past(a_q[0]) && b_q[0] == $past(b_q[0])));

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
   parameter int OP_W  = 8,
   parameter int ACC_W = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [OP_W-1:0]   u_in,
   input  logic signed [OP_W-1:0]   l_in,
   output logic signed [OP_W-1:0]   d_out,
   output logic signed [OP_W-1:0]   r_out,
   output logic signed [ACC_W-1:0]  acc
);
   localparam int PROD_W = 2 * OP_W;

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;

   assign prod     = u_in * l_in;
   assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc   <= '0;
         d_out <= '0;
         r_out <= '0;
      end else if (en) begin
         acc   <= acc + prod_ext;
         d_out <= u_in;
         r_out <= l_in;
      end
   end

   // R1: a clear empties the accumulator
   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));

   // R7: outside a compute step the total is frozen
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc));

   // R4: operands move one cell down and right per compute step (forms the skew)
   p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> (d_out == $past(u_in) && r_out == $past(l_in)));

   // R3: a zero operand leaves the total unchanged
   p_zero_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && (u_in == '0 || l_in == '0)) |=> $stable(acc));

endmodule

// File: rtl/sa_matmul.sv
module sa_matmul
   import sa_pkg::*;
#(
   parameter int DIM   = 2,
   parameter int OP_W  = 8,
   parameter int ACC_W = 18
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [DIM*DIM*OP_W-1:0]   a_mat,
   input  logic [DIM*DIM*OP_W-1:0]   b_mat,
   output logic                      busy,
   output logic                      done,
   output logic [DIM*DIM*ACC_W-1:0]  c_mat
);
   localparam int NSTEP  = run_steps(DIM);
   localparam int STEP_W = $clog2(NSTEP + 1);

   // Elaboration-time parameter checks
   if (DIM < 1) begin : g_bad_dim
      $error("sa_matmul: DIM must be at least 1");
   end
   if (OP_W < 2) begin : g_bad_opw
      $error("sa_matmul: OP_W must be at least 2");
   end
   if (ACC_W < acc_width_min(OP_W, DIM)) begin : g_bad_accw
      $error("sa_matmul: ACC_W too narrow for a full dot product");
   end

   logic [STEP_W-1:0] step;
   logic              en;
   logic              clr;

   logic signed [OP_W-1:0]  left_edge [DIM];
   logic signed [OP_W-1:0]  top_edge  [DIM];
   logic signed [OP_W-1:0]  hbus [DIM][DIM+1];
   logic signed [OP_W-1:0]  vbus [DIM+1][DIM];
   logic signed [ACC_W-1:0] tot  [DIM][DIM];

   sa_ctrl #(.DIM(DIM)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .step  (step),
      .en    (en),
      .clr   (clr),
      .busy  (busy),
      .done  (done)
   );

   sa_feeder #(.DIM(DIM), .OP_W(OP_W)) u_feed (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .a_mat     (a_mat),
      .b_mat     (b_mat),
      .step      (step),
      .left_edge (left_edge),
      .top_edge  (top_edge)
   );

   for (genvar i = 0; i < DIM; i++) begin : g_row
      assign hbus[i][0] = left_edge[i];
      assign vbus[0][i] = top_edge[i];
      for (genvar j = 0; j < DIM; j++) begin : g_col
         sa_pe #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (en),
            .u_in  (vbus[i][j]),
            .l_in  (hbus[i][j]),
            .d_out (vbus[i+1][j]),
            .r_out (hbus[i][j+1]),
            .acc   (tot[i][j])
         );
         assign c_mat[(i*DIM+j)*ACC_W +: ACC_W] = tot[i][j];
      end
   end

   // R6: done and busy never overlap
   p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: results are held between runs
   p_hold_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(c_mat));

   // R1: a start clears all totals on the next cycle
   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (c_mat == '0));

endmodule

// File: tb/sa_matmul_bench.sv
`timescale 1ns/1ps
module sa_matmul_bench;
   localparam int DIM   = 2;
   localparam int OP_W  = 8;
   localparam int ACC_W = 18;
   localparam int NE    = DIM * DIM;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     start = 1'b0;
   logic [NE*OP_W-1:0]       a_mat = '0;
   logic [NE*OP_W-1:0]       b_mat = '0;
   logic                     busy;
   logic                     done;
   logic [NE*ACC_W-1:0]      c_mat;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int am [NE];
   int bm [NE];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sa_matmul #(.DIM(DIM), .OP_W(OP_W), .ACC_W(ACC_W)) u_sa_matmul (
      .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat),
      .b_mat(b_mat), .busy(busy), .done(done), .c_mat(c_mat)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int cval(input int r, input int c);
      logic signed [ACC_W-1:0] v;
      v = c_mat[(r*DIM+c)*ACC_W +: ACC_W];
      return int'(v);
   endfunction

   function automatic int refc(input int r, input int c);
      int s = 0;
      for (int k = 0; k < DIM; k++) s += am[r*DIM+k] * bm[k*DIM+c];
      return s;
   endfunction

   task automatic load(input int a0, input int a1, input int a2, input int a3,
                       input int b0, input int b1, input int b2, input int b3);
      am[0] = a0; am[1] = a1; am[2] = a2; am[3] = a3;
      bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
      for (int e = 0; e < NE; e++) begin
         a_mat[e*OP_W +: OP_W] = OP_W'(am[e]);
         b_mat[e*OP_W +: OP_W] = OP_W'(bm[e]);
      end
   endtask

   // Pulse start; returns on the falling edge right after edge 0.
   task automatic kick();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic step_edge(); @(negedge clk); endtask

   task automatic chk_all(input string req);
      for (int r = 0; r < DIM; r++)
         for (int c = 0; c < DIM; c++)
            chk(req, $sformatf("C(%0d,%0d)", r, c), cval(r, c), refc(r, c));
   endtask

   // Full timing walk of one run (R3, R4, R5, R6)
   task automatic run_timed(input string tag);
      kick();
      chk("R1", {tag, " cleared after start"}, cval(1, 1), 0);
      chk("R6", {tag, " busy at step1"}, int'(busy), 1);
      step_edge();   // after edge 1
      chk("R3", {tag, " C00 partial"}, cval(0, 0), am[0]*bm[0]);
      chk("R4", {tag, " C11 zero at edge1"}, cval(1, 1), 0);
      step_edge();   // after edge 2
      chk("R3", {tag, " C00 final"}, cval(0, 0), refc(0, 0));
      chk("R4", {tag, " C01 partial"}, cval(0, 1), am[0]*bm[1]);
      chk("R4", {tag, " C10 partial"}, cval(1, 0), am[2]*bm[0]);
      chk("R4", {tag, " C11 zero at edge2"}, cval(1, 1), 0);
      step_edge();   // after edge 3
      chk("R4", {tag, " C01 final"}, cval(0, 1), refc(0, 1));
      chk("R4", {tag, " C10 final"}, cval(1, 0), refc(1, 0));
      chk("R4", {tag, " C11 partial"}, cval(1, 1), am[2]*bm[1]);
      chk("R6", {tag, " no done before last"}, int'(done), 0);
      step_edge();   // after edge 4
      chk("R5", {tag, " C11 final"}, cval(1, 1), refc(1, 1));
      chk("R6", {tag, " done high"}, int'(done), 1);
      chk("R6", {tag, " busy low"}, int'(busy), 0);
      chk_all("R2");
      step_edge();   // after edge 5
      chk("R6", {tag, " done one cycle"}, int'(done), 0);
   endtask

   task automatic t_reset();
      chk("R1", "reset done", int'(done), 0);
      chk("R1", "reset busy", int'(busy), 0);
      for (int e = 0; e < NE; e++) chk("R1", "reset total", cval(e / DIM, e % DIM), 0);
   endtask

   task automatic t_basic();
      load(1, 2, 3, 4, 5, 6, 7, 8);
      run_timed("basic");
   endtask

   task automatic t_signed();
      load(-3, 7, 11, -5, 9, -2, -4, 13);
      run_timed("signed");
   endtask

   task automatic t_extremes();
      load(-128, -128, 127, -128, -128, 127, -128, -128);
      run_timed("extreme");
      load(127, 127, 127, 127, 127, 127, 127, 127);
      run_timed("maxpos");
   endtask

   task automatic t_hold_ignore();
      int keep [NE];
      load(2, -1, 4, 6, 3, 5, -7, 1);
      kick();
      // R7: input changes mid-run do not alter this run
      a_mat = '1; b_mat = '1;
      repeat (4) step_edge();
      chk_all("R7");
      for (int e = 0; e < NE; e++) keep[e] = cval(e / DIM, e % DIM);
      a_mat = {NE{8'sd99}}; b_mat = {NE{-8'sd77}};
      repeat (6) step_edge();
      for (int e = 0; e < NE; e++)
         chk("R7", "held total", cval(e / DIM, e % DIM), keep[e]);
      chk("R7", "no spurious done", int'(done), 0);
   endtask

   task automatic t_restart();
      load(9, 9, 9, 9, 9, 9, 9, 9);
      kick();
      step_edge();   // after edge 1 of the abandoned run
      load(1, -2, -3, 4, -1, 2, 5, -6);
      run_timed("restart");
      chk("R8", "restart C11", cval(1, 1), refc(1, 1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_signed();
      t_extremes();
      t_hold_ignore();
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cyc >= 5000);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule